// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier with Power Sequencer

This block provides the symbol arithmetic for a Reed-Solomon code over 12-bit symbols. A 12-bit symbol is treated as a pair of 6-bit halves. Each half is an element of GF(64), reduced by x^6+x+1. The full field is the quadratic extension of GF(64) defined by X^2 + X + A^-1, where the constant A^-1 is the GF(64) element 0x21. Two operands presented with a valid strobe produce their product one clock later. The operands are not restricted to a flat 12-bit polynomial basis; the block uses the tower representation throughout.

A second function walks the powers of the fixed primitive element 0xE01. A single start pulse loads the value 1 at index 0. Each following clock multiplies the value by 0xE01 and increments the index. The run covers all 4095 nonzero field elements, one per cycle, and then stops. Logarithm and antilogarithm tables can be filled directly from this stream. A flag output rises if the value 1 comes back before the run is complete, which would mean the element is not primitive.

Top module: `gf_tower_mul`

## Requirements
- R1: For operands whose upper six bits are both zero, the product has a zero upper half. Its lower half is the GF(64) product reduced by x^6+x+1. For example, 0x020 times 0x020 gives 0x030.
- R2: For any operands a = {ah,al} and b = {bh,bl}, the product takes its upper six bits from (ah^al)(bh^bl) ^ al·bl. Its lower six bits come from ah·bh·0x21 ^ al·bl. Every multiplication is in GF(64).
- R3: If either operand is 0, the product is 0.
- R4: If either operand is 1, the product equals the other operand.
- R5: When op_valid is sampled high, prod_valid is high one cycle later, with the new product on prod. When op_valid is low, prod_valid is low the next cycle and prod keeps its previous value.
- R6: One cycle after seq_start is sampled high, pow_valid is 1, pow_value is 1 and pow_index is 0.
- R7: While the run is active and not at its last index, each clock sets pow_value to the previous value times 0xE01 and increments pow_index by one.
- R8: A run emits 4095 distinct nonzero values, at indices 0 to 4094. pow_valid drops the cycle after index 4094. The value after the last one, times 0xE01, is 1. seq_repeat stays low throughout.
- R9: A seq_start during an active run restarts the sequence at value 1, index 0.
- R10: Multiplication is commutative: a·b equals b·a.
- R11: After reset, prod_valid, prod, pow_valid, pow_value, pow_index and seq_repeat are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand |
| prod_valid | output | 1 | Product valid |
| prod | output | 12 | Registered product |
| seq_start | input | 1 | Start or restart the power sequence |
| pow_valid | output | 1 | Sequence output valid |
| pow_value | output | 12 | Current power of the generator |
| pow_index | output | 12 | Exponent of the current power |
| seq_repeat | output | 1 | Value 1 seen again before the run completed |

## Verification
The bench targets several corner cases, and each has a visible failure signature. Operands with zero upper halves expose a wrong reduction constant, which shows up as a wrong lower half, and a swapped term in the extension, which leaves a nonzero upper half. The A^-1 constant only affects products where both upper halves are nonzero, so random operands are needed to catch a wrong value. The full 4095-step run catches a generator or multiplier fault: a repeated value, or an early return to 1 that raises seq_repeat. A restart in mid-run and the drop of pow_valid after index 4094 catch an off-by-one in the index counter or a sequencer that wraps around instead of stopping.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
    localparam int HALF_W = 6;
    localparam int SYM_W  = 2 * HALF_W;
    // x^6 + x + 1, applied once bit HALF_W of the shifted operand sets
    localparam logic [HALF_W:0]   HALF_POLY = 7'h43;
    // A^-1, the constant term of the extension polynomial
    localparam logic [HALF_W-1:0] EXT_K     = 6'h21;
    localparam logic [SYM_W-1:0]  GEN_ELEM  = 12'hE01;

    typedef logic [HALF_W-1:0] half_t;
    typedef struct packed {
        half_t hi;
        half_t lo;
    } tower_t;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
    parameter int          HW   = gf_tower_pkg::HALF_W,
    parameter logic [HW:0] POLY = gf_tower_pkg::HALF_POLY
) (
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    output logic [HW-1:0] y
);
    always_comb begin
        logic [HW:0]   sh;
        logic [HW-1:0] acc;
        acc = '0;
        sh  = {1'b0, b};
        for (int i = 0; i < HW; i++) begin
            if (a[i]) acc = acc ^ sh[HW-1:0];
            sh = sh << 1;
            if (sh[HW]) sh = sh ^ POLY;
        end
        y = acc;
    end
endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul #(
    parameter int            HW   = gf_tower_pkg::HALF_W,
    parameter logic [HW:0]   POLY = gf_tower_pkg::HALF_POLY,
    parameter logic [HW-1:0] KCON = gf_tower_pkg::EXT_K,
    localparam int           SW   = 2 * HW
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    output logic [SW-1:0] y
);
    logic [HW-1:0] ah, al, bh, bl;
    logic [HW-1:0] p_sum, p_lo, p_hh, p_k;

    assign ah = a[SW-1:HW];
    assign al = a[HW-1:0];
    assign bh = b[SW-1:HW];
    assign bl = b[HW-1:0];

    gf64_mul #(.HW(HW), .POLY(POLY)) u_sum (.a(ah ^ al), .b(bh ^ bl), .y(p_sum));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_lo  (.a(al),      .b(bl),      .y(p_lo));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_hh  (.a(ah),      .b(bh),      .y(p_hh));
    gf64_mul #(.HW(HW), .POLY(POLY)) u_k   (.a(p_hh),    .b(KCON),    .y(p_k));

    assign y = {p_sum ^ p_lo, p_k ^ p_lo};
endmodule

// File: rtl/gf_power_seq.sv
module gf_power_seq #(
    parameter int            HW   = gf_tower_pkg::HALF_W,
    parameter logic [HW:0]   POLY = gf_tower_pkg::HALF_POLY,
    parameter logic [HW-1:0] KCON = gf_tower_pkg::EXT_K,
    parameter logic [2*HW-1:0] GEN = gf_tower_pkg::GEN_ELEM,
    localparam int           SW   = 2 * HW,
    localparam int           LAST = (1 << SW) - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          run,
    output logic [SW-1:0] value,
    output logic [SW-1:0] index,
    output logic          early_one
);
    logic [SW-1:0] next_val;

    gf4096_mul #(.HW(HW), .POLY(POLY), .KCON(KCON)) u_step (
        .a(value), .b(GEN), .y(next_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            value <= '0;
            index <= '0;
        end else if (start) begin
            run   <= 1'b1;
            value <= SW'(1);
            index <= '0;
        end else if (run) begin
            if (index == SW'(LAST)) begin
                run <= 1'b0;
            end else begin
                value <= next_val;
                index <= index + 1'b1;
            end
        end
    end

    assign early_one = run && (index != '0) && (value == SW'(1));
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul #(
    parameter int  HW      = gf_tower_pkg::HALF_W,
    parameter bit  REG_OUT = 1'b1,
    localparam int SYM_W   = 2 * HW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [SYM_W-1:0] op_a,
    input  logic [SYM_W-1:0] op_b,
    output logic             prod_valid,
    output logic [SYM_W-1:0] prod,
    input  logic             seq_start,
    output logic             pow_valid,
    output logic [SYM_W-1:0] pow_value,
    output logic [SYM_W-1:0] pow_index,
    output logic             seq_repeat
);
    logic [SYM_W-1:0] raw_prod;

    gf4096_mul #(.HW(HW)) u_mul (.a(op_a), .b(op_b), .y(raw_prod));

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    prod_valid <= 1'b0;
                    prod       <= '0;
                end else begin
                    prod_valid <= op_valid;
                    if (op_valid) prod <= raw_prod;
                end
            end
        end else begin : g_comb
            assign prod_valid = op_valid;
            assign prod       = raw_prod;
        end
    endgenerate

    gf_power_seq #(.HW(HW)) u_seq (
        .clk(clk), .rst(rst), .start(seq_start),
        .run(pow_valid), .value(pow_value), .index(pow_index),
        .early_one(seq_repeat)
    );
endmodule

// File: rtl/gf_tower_mul_chk.sv
module gf_tower_mul_chk #(
    parameter int  SYM_W   = 12,
    parameter bit  REG_OUT = 1'b1,
    localparam int LAST    = (1 << SYM_W) - 2
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [SYM_W-1:0] op_a,
    input logic [SYM_W-1:0] op_b,
    input logic             prod_valid,
    input logic [SYM_W-1:0] prod,
    input logic             seq_start,
    input logic             pow_valid,
    input logic [SYM_W-1:0] pow_value,
    input logic [SYM_W-1:0] pow_index,
    input logic             seq_repeat
);
    generate
        if (REG_OUT) begin : g_prod_chk
            p_zero_r3: assert property (@(posedge clk) disable iff (rst)
                op_valid && (op_a == '0 || op_b == '0) |=> prod == '0);
            p_one_r4: assert property (@(posedge clk) disable iff (rst)
                op_valid && op_a == SYM_W'(1) |=> prod == $past(op_b));
            p_valid_r5: assert property (@(posedge clk) disable iff (rst)
                op_valid |=> prod_valid);
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !op_valid |=> !prod_valid && $stable(prod));
        end
    endgenerate

    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> pow_valid && pow_value == SYM_W'(1) && pow_index == '0);
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        pow_valid && !seq_start && pow_index != SYM_W'(LAST)
        |=> pow_valid && pow_index == $past(pow_index) + 1'b1);
    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        pow_valid && !seq_start && pow_index == SYM_W'(LAST) |=> !pow_valid);
    p_no_repeat_r8: assert property (@(posedge clk) disable iff (rst)
        !seq_repeat);
    p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        pow_valid |-> pow_value != '0);
endmodule

bind gf_tower_mul gf_tower_mul_chk #(.SYM_W(SYM_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/gf_tower_mul_tb.sv
`timescale 1ns/1ps
module gf_tower_mul_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [11:0] op_a = '0, op_b = '0;
    logic        seq_start = 1'b0;
    logic        prod_valid, pow_valid, seq_repeat;
    logic [11:0] prod, pow_value, pow_index;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gf_tower_mul u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .prod_valid(prod_valid), .prod(prod), .seq_start(seq_start),
        .pow_valid(pow_valid), .pow_value(pow_value), .pow_index(pow_index),
        .seq_repeat(seq_repeat)
    );

    // Behavioural field arithmetic: full polynomial product, then long division
    function automatic int ref_mul6(int a, int b);
        int p = 0;
        for (int i = 0; i < 6; i++) if ((a >> i) & 1) p ^= (b << i);
        for (int k = 10; k >= 6; k--) if ((p >> k) & 1) p ^= ('h43 << (k - 6));
        return p & 'h3f;
    endfunction

    function automatic int ref_mul12(int a, int b);
        int ah = (a >> 6) & 63, al = a & 63, bh = (b >> 6) & 63, bl = b & 63;
        int lo = ref_mul6(al, bl);
        int hi = ref_mul6(ah ^ al, bh ^ bl) ^ lo;
        int lw = ref_mul6(ref_mul6(ah, bh), 'h21) ^ lo;
        return (hi << 6) | lw;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle reference model
    int  e_pv = 0, e_prod = 0, e_powv = 0, e_val = 0, e_idx = 0;
    bit  seen [4096];

    always @(posedge clk) begin
        if (rst) begin
            e_pv = 0; e_prod = 0; e_powv = 0; e_val = 0; e_idx = 0;
        end else begin
            e_pv = op_valid;
            if (op_valid) e_prod = ref_mul12(op_a, op_b);
            if (seq_start) begin
                e_powv = 1; e_val = 1; e_idx = 0;
                for (int i = 0; i < 4096; i++) seen[i] = 0;
            end else if (e_powv != 0) begin
                if (e_idx == 4094) e_powv = 0;
                else begin
                    e_val = ref_mul12(e_val, 'hE01);
                    e_idx++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R5 prod_valid", prod_valid, e_pv);
            check("R2 prod", prod, e_prod);
            check("R7 pow_valid", pow_valid, e_powv);
            if (e_powv != 0) begin
                check("R7 pow_value", pow_value, e_val);
                check("R7 pow_index", pow_index, e_idx);
                check("R8 distinct", seen[pow_value], 0);
                seen[pow_value] = 1;
                if (e_idx == 4094) check("R8 wraps to 1", ref_mul12(e_val, 'hE01), 1);
            end
            check("R8 seq_repeat", seq_repeat, 0);
        end
    end

    task automatic mul_op(int a, int b);
        op_valid = 1'b1; op_a = 12'(a); op_b = 12'(b);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    logic [11:0] lfsr = 12'hACE;
    function automatic logic [11:0] step(logic [11:0] s);
        return {s[10:0], s[11] ^ s[10] ^ s[9] ^ s[3]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 prod_valid", prod_valid, 0);
        check("R11 prod", prod, 0);
        check("R11 pow_valid", pow_valid, 0);
        check("R11 pow_value", pow_value, 0);
        check("R11 pow_index", pow_index, 0);
        check("R11 seq_repeat", seq_repeat, 0);
        rst = 1'b0;
        @(negedge clk);

        mul_op('h020, 'h020); check("R1 low half", prod, 'h030);
        mul_op('h03f, 'h002); check("R1 reduce", prod, ref_mul6('h3f, 2));
        mul_op('h000, 'hABC); check("R3 zero a", prod, 0);
        mul_op('h5A5, 'h000); check("R3 zero b", prod, 0);
        mul_op('h001, 'h9C3); check("R4 one a", prod, 'h9C3);
        mul_op('h7E2, 'h001); check("R4 one b", prod, 'h7E2);
        mul_op('hFC0, 'hFC0); check("R2 high halves", prod, ref_mul12('hFC0, 'hFC0));
        // R5: idle cycles keep prod
        repeat (3) @(negedge clk);
        check("R5 hold", prod, ref_mul12('hFC0, 'hFC0));

        for (int i = 0; i < 40; i++) begin
            int x, y, p1;
            lfsr = step(lfsr); x = lfsr;
            lfsr = step(lfsr); y = lfsr;
            mul_op(x, y); p1 = prod;
            mul_op(y, x); check("R10 commute", prod, p1);
        end

        // R6 / R9: start, run, restart mid-run
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        check("R6 start value", pow_value, 1);
        check("R6 start index", pow_index, 0);
        repeat (100) @(negedge clk);
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        check("R9 restart value", pow_value, 1);
        check("R9 restart index", pow_index, 0);

        // Full run with random products in parallel
        for (int i = 0; i < 4094; i++) begin
            lfsr = step(lfsr);
            op_valid = lfsr[0]; op_a = lfsr; op_b = step(lfsr);
            @(negedge clk);
        end
        op_valid = 1'b0;
        check("R8 last index", pow_index, 4094);
        @(negedge clk);
        check("R8 stopped", pow_valid, 0);
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule